// File: doc/BRIEF.md
# Interrupt Controller Register Bank

This block holds the enable, pending and priority state for up to 32 external interrupt lines and picks the line that should be serviced next. Software reaches the state through a single-cycle, word-wide register port. Enable and pending state are each changed through a pair of addresses. One address sets the bits written as one. The other address clears the bits written as one. Priorities are 2-bit fields, four lines to a 32-bit word.

Each request input that is high at a clock edge marks its line pending, whatever the line's enable state. A combinational arbiter looks at the lines that are both enabled and pending. It reports the one with the numerically lowest priority value, plus a valid flag. The servicing logic pulses an acknowledge input, which clears the pending bit of the line reported in that cycle.

Top module: `irq_ctrl_bank`

## Requirements
- R1: Reset (synchronous, active high) clears every enable, pending and priority bit. While and after reset, irq_valid is low and irq_id is 0.
- R2: A write to byte offset 0x000 enables every line whose data bit is one. Data bits that are zero leave their lines unchanged.
- R3: A write to byte offset 0x080 disables every line whose data bit is one. Data bits that are zero leave their lines unchanged.
- R4: A read at offset 0x000 or at offset 0x080 returns the current enable mask, with bit n holding line n.
- R5: A write to offset 0x100 sets the pending bit of each line written as one. A write to offset 0x180 clears the pending bit of each line written as one. A read at either offset returns the pending mask.
- R6: A request input that is high at a clock edge sets its line's pending bit, whether the line is enabled or not. When a set and a clear reach the same line's pending bit in one cycle, the set wins.
- R7: The priority of line n is held in the word at offset 0x300 + 4*(n/4), in bits (n%4)*8+7 down to (n%4)*8+6. Writes to the lower six bits of each byte are discarded, and those bits read as zero.
- R8: A write to a priority word takes effect only when all four byte strobes are set. On the set and clear addresses, data bits in a byte whose strobe is low count as zero.
- R9: irq_valid is high in the same cycle as any line that is both enabled and pending. irq_id then names the qualifying line with the lowest priority value, and on equal values the lowest line number. With no qualifying line, irq_valid is low and irq_id is 0.
- R10: When irq_ack is high at a clock edge while irq_valid is high, the pending bit of the line on irq_id is cleared, unless a set reaches that line in the same cycle. When irq_valid is low, irq_ack has no effect.
- R11: An address outside the mapped words, or one whose two low bits are not zero, reads as zero, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access strobe for this cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte address of the register word |
| reg_be | input | 4 | Byte strobes of the write data |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_req | input | 32 | Interrupt request lines |
| irq_ack | input | 1 | Acknowledge of the line shown on irq_id |
| irq_valid | output | 1 | A line is enabled and pending |
| irq_id | output | 5 | Number of the selected line |

## Verification
The embedded assertions watch the following on every cycle:
- Reset leaves all state at zero.
- Set-enable and clear-enable writes take effect on exactly the bits written as one.
- A set request always leaves its pending bit high.
- An acknowledge clears the pending bit of the line that was shown.
- A priority write with a missing strobe leaves the priorities unchanged.
- The reported line is always enabled and pending, and when no line is reported, none qualifies.

Only the bench's scenarios can show the rest:
- The address map and the priority lane positions, including line 31.
- That the winner is the lowest priority value, with ties going to the lowest number.
- That unmapped addresses have no effect.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int REG_AW = 12;
    localparam int REG_DW = 32;
    localparam int LANES  = REG_DW / 8;

    // Byte offsets of the register words
    localparam logic [REG_AW-1:0] OFS_EN_SET = 12'h000;
    localparam logic [REG_AW-1:0] OFS_EN_CLR = 12'h080;
    localparam logic [REG_AW-1:0] OFS_PD_SET = 12'h100;
    localparam logic [REG_AW-1:0] OFS_PD_CLR = 12'h180;
    localparam logic [REG_AW-1:0] OFS_PRIO   = 12'h300;

    // Write selects produced by the decoder
    typedef struct packed {
        logic en_set;
        logic en_clr;
        logic pd_set;
        logic pd_clr;
        logic prio_wr;
    } irqc_wsel_t;

    // Source of the read data
    typedef enum logic [1:0] {
        RS_NONE = 2'd0,
        RS_EN   = 2'd1,
        RS_PEND = 2'd2,
        RS_PRIO = 2'd3
    } irqc_rsrc_e;

    // Expands byte strobes into a bit mask
    function automatic logic [REG_DW-1:0] strobe_mask(input logic [LANES-1:0] be);
        logic [REG_DW-1:0] m;
        for (int b = 0; b < LANES; b++) begin
            m[b*8 +: 8] = {8{be[b]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int PRIO_WORDS = 8,
    parameter int WIDX_W     = 3
) (
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    output irqc_wsel_t        wsel,
    output irqc_rsrc_e        rsrc,
    output logic [WIDX_W-1:0] prio_idx
);
    localparam int WA_W = REG_AW - 2;
    localparam logic [WA_W-1:0] W_EN_SET = OFS_EN_SET[REG_AW-1:2];
    localparam logic [WA_W-1:0] W_EN_CLR = OFS_EN_CLR[REG_AW-1:2];
    localparam logic [WA_W-1:0] W_PD_SET = OFS_PD_SET[REG_AW-1:2];
    localparam logic [WA_W-1:0] W_PD_CLR = OFS_PD_CLR[REG_AW-1:2];
    localparam logic [WA_W-1:0] W_PRIO   = OFS_PRIO[REG_AW-1:2];
    localparam logic [WA_W-1:0] W_PRIO_E = W_PRIO + WA_W'(PRIO_WORDS);

    logic [WA_W-1:0] waddr;
    logic [WA_W-1:0] poff;
    logic            aligned;
    logic            wr;

    assign waddr   = reg_addr[REG_AW-1:2];
    assign aligned = (reg_addr[1:0] == 2'b00);
    assign wr      = reg_en && reg_we && aligned;
    assign poff    = waddr - W_PRIO;

    always_comb begin
        wsel     = '0;
        rsrc     = RS_NONE;
        prio_idx = poff[WIDX_W-1:0];
        if (aligned) begin
            if (waddr == W_EN_SET || waddr == W_EN_CLR) begin
                rsrc = RS_EN;
            end else if (waddr == W_PD_SET || waddr == W_PD_CLR) begin
                rsrc = RS_PEND;
            end else if (waddr >= W_PRIO && waddr < W_PRIO_E) begin
                rsrc = RS_PRIO;
            end
        end
        if (wr) begin
            wsel.en_set  = (waddr == W_EN_SET);
            wsel.en_clr  = (waddr == W_EN_CLR);
            wsel.pd_set  = (waddr == W_PD_SET);
            wsel.pd_clr  = (waddr == W_PD_CLR);
            wsel.prio_wr = (waddr >= W_PRIO && waddr < W_PRIO_E);
        end
    end

endmodule

// File: rtl/irqc_line_state.sv
module irqc_line_state #(
    parameter int NUM_LINES = 32,
    parameter int ID_W      = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] en_set_mask,
    input  logic [NUM_LINES-1:0] en_clr_mask,
    input  logic [NUM_LINES-1:0] pd_set_mask,
    input  logic [NUM_LINES-1:0] pd_clr_mask,
    input  logic [NUM_LINES-1:0] irq_req,
    input  logic                 ack_fire,
    input  logic [ID_W-1:0]      ack_id,
    output logic [NUM_LINES-1:0] en_q,
    output logic [NUM_LINES-1:0] pend_q
);
    logic [NUM_LINES-1:0] set_vec;
    logic [NUM_LINES-1:0] clr_vec;
    logic [NUM_LINES-1:0] ack_vec;

    assign ack_vec = ack_fire ? (NUM_LINES'(1) << ack_id) : '0;
    assign set_vec = pd_set_mask | irq_req;
    assign clr_vec = pd_clr_mask | ack_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pend_q <= '0;
        end else begin
            en_q   <= (en_q & ~en_clr_mask) | en_set_mask;
            pend_q <= (pend_q & ~clr_vec) | set_vec;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (en_q == '0 && pend_q == '0)); // R1

    AST_EN_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        en_set_mask != '0 |=> (en_q & $past(en_set_mask)) == $past(en_set_mask)); // R2

    AST_EN_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (en_clr_mask != '0 && en_set_mask == '0) |=> (en_q & $past(en_clr_mask)) == '0); // R3

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_vec != '0 |=> (pend_q & $past(set_vec)) == $past(set_vec)); // R6

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ack_fire && !set_vec[ack_id]) |=> !pend_q[$past(ack_id)]); // R10

endmodule

// File: rtl/irqc_prio_store.sv
module irqc_prio_store #(
    parameter int NUM_LINES  = 32,
    parameter int PB         = 2,
    parameter int PRIO_WORDS = 8,
    parameter int WIDX_W     = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_req,
    input  logic [3:0]                wr_be,
    input  logic [WIDX_W-1:0]         widx,
    input  logic [4*PB-1:0]           wfields,
    output logic [NUM_LINES*PB-1:0]   prio_flat,
    output logic [31:0]               rd_word
);
    logic wr_ok;
    assign wr_ok = wr_req && (wr_be == 4'hF);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        localparam int WORD = g / 4;
        localparam int LANE = g % 4;
        always_ff @(posedge clk) begin
            if (rst) begin
                prio_flat[g*PB +: PB] <= '0;
            end else if (wr_ok && widx == WIDX_W'(WORD)) begin
                prio_flat[g*PB +: PB] <= wfields[LANE*PB +: PB];
            end
        end
    end

    // Read word: stored bits at the top of each lane, the rest zero
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (widx == WIDX_W'(i / 4)) begin
                rd_word[(i % 4)*8 + 8 - PB +: PB] = prio_flat[i*PB +: PB];
            end
        end
    end

    AST_PRIO_PARTIAL_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_req && wr_be != 4'hF) |=> $stable(prio_flat)); // R8

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int NUM_LINES = 32,
    parameter int PB        = 2,
    parameter int ID_W      = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_LINES-1:0]    en,
    input  logic [NUM_LINES-1:0]    pend,
    input  logic [NUM_LINES*PB-1:0] prio_flat,
    output logic                    valid,
    output logic [ID_W-1:0]         id
);
    logic [PB-1:0] best_p;

    // Strict compare keeps the lower line number on equal priority
    always_comb begin
        valid  = 1'b0;
        id     = '0;
        best_p = '1;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (en[i] && pend[i] && (!valid || prio_flat[i*PB +: PB] < best_p)) begin
                valid  = 1'b1;
                id     = ID_W'(i);
                best_p = prio_flat[i*PB +: PB];
            end
        end
    end

    AST_WINNER_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        valid |-> (en[id] && pend[id])); // R9

    AST_IDLE_WHEN_NONE: assert property (@(posedge clk) disable iff (rst)
        !valid |-> ((en & pend) == '0 && id == '0)); // R9

endmodule

// File: rtl/irq_ctrl_bank.sv
module irq_ctrl_bank
    import irqc_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int PB        = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        reg_en,
    input  logic                        reg_we,
    input  logic [REG_AW-1:0]           reg_addr,
    input  logic [LANES-1:0]            reg_be,
    input  logic [REG_DW-1:0]           reg_wdata,
    output logic [REG_DW-1:0]           reg_rdata,
    input  logic [NUM_LINES-1:0]        irq_req,
    input  logic                        irq_ack,
    output logic                        irq_valid,
    output logic [$clog2(NUM_LINES)-1:0] irq_id
);
    localparam int ID_W       = $clog2(NUM_LINES);
    localparam int PRIO_WORDS = (NUM_LINES + 3) / 4;
    localparam int WIDX_W     = (PRIO_WORDS > 1) ? $clog2(PRIO_WORDS) : 1;

    irqc_wsel_t            wsel;
    irqc_rsrc_e            rsrc;
    logic [WIDX_W-1:0]     prio_idx;
    logic [REG_DW-1:0]     wmask;
    logic [NUM_LINES-1:0]  data_bits;
    logic [NUM_LINES-1:0]  en_q;
    logic [NUM_LINES-1:0]  pend_q;
    logic [NUM_LINES*PB-1:0] prio_flat;
    logic [31:0]           prio_rd;
    logic [4*PB-1:0]       wfields;
    logic                  ack_fire;

    assign wmask     = reg_wdata & strobe_mask(reg_be);
    assign data_bits = wmask[NUM_LINES-1:0];
    assign ack_fire  = irq_ack && irq_valid;

    for (genvar k = 0; k < 4; k++) begin : g_field
        assign wfields[k*PB +: PB] = reg_wdata[k*8 + 8 - PB +: PB];
    end

    irqc_decode #(.PRIO_WORDS(PRIO_WORDS), .WIDX_W(WIDX_W)) i_decode (
        .reg_en   (reg_en),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .wsel     (wsel),
        .rsrc     (rsrc),
        .prio_idx (prio_idx)
    );

    irqc_line_state #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) i_lines (
        .clk         (clk),
        .rst         (rst),
        .en_set_mask (wsel.en_set ? data_bits : '0),
        .en_clr_mask (wsel.en_clr ? data_bits : '0),
        .pd_set_mask (wsel.pd_set ? data_bits : '0),
        .pd_clr_mask (wsel.pd_clr ? data_bits : '0),
        .irq_req     (irq_req),
        .ack_fire    (ack_fire),
        .ack_id      (irq_id),
        .en_q        (en_q),
        .pend_q      (pend_q)
    );

    irqc_prio_store #(.NUM_LINES(NUM_LINES), .PB(PB), .PRIO_WORDS(PRIO_WORDS),
                      .WIDX_W(WIDX_W)) i_prio (
        .clk       (clk),
        .rst       (rst),
        .wr_req    (wsel.prio_wr),
        .wr_be     (reg_be),
        .widx      (prio_idx),
        .wfields   (wfields),
        .prio_flat (prio_flat),
        .rd_word   (prio_rd)
    );

    irqc_arbiter #(.NUM_LINES(NUM_LINES), .PB(PB), .ID_W(ID_W)) i_arb (
        .clk       (clk),
        .rst       (rst),
        .en        (en_q),
        .pend      (pend_q),
        .prio_flat (prio_flat),
        .valid     (irq_valid),
        .id        (irq_id)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (rsrc)
            RS_EN:   reg_rdata[NUM_LINES-1:0] = en_q;
            RS_PEND: reg_rdata[NUM_LINES-1:0] = pend_q;
            RS_PRIO: reg_rdata = prio_rd;
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: tb/test_irq_ctrl_bank.sv
module test_irq_ctrl_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 26;
    // op: 0 write, 1 read compare, 2 arbiter compare ({valid at bit 8, id})
    localparam logic [85:0] TBL [0:NT-1] = '{
        {2'd0, 12'h000, 4'hF, 32'h0000_00F0, 32'h0, 4'd2},  // R2
        {2'd1, 12'h000, 4'hF, 32'h0,         32'h0000_00F0, 4'd4},  // R4
        {2'd1, 12'h080, 4'hF, 32'h0,         32'h0000_00F0, 4'd4},  // R4
        {2'd0, 12'h080, 4'hF, 32'h0000_0030, 32'h0, 4'd3},  // R3
        {2'd1, 12'h000, 4'hF, 32'h0,         32'h0000_00C0, 4'd3},  // R3
        {2'd0, 12'h100, 4'hF, 32'h0000_00A0, 32'h0, 4'd5},  // R5
        {2'd1, 12'h100, 4'hF, 32'h0,         32'h0000_00A0, 4'd5},  // R5
        {2'd2, 12'h000, 4'hF, 32'h0,         32'h0000_0107, 4'd9},  // R9
        {2'd0, 12'h304, 4'hF, 32'h7F00_0000, 32'h0, 4'd7},  // R7
        {2'd1, 12'h304, 4'hF, 32'h0,         32'h4000_0000, 4'd7},  // R7
        {2'd0, 12'h000, 4'hF, 32'h0000_0020, 32'h0, 4'd2},  // R2
        {2'd2, 12'h000, 4'hF, 32'h0,         32'h0000_0105, 4'd9},  // R9
        {2'd0, 12'h304, 4'hF, 32'h40C0_8000, 32'h0, 4'd7},  // R7
        {2'd2, 12'h000, 4'hF, 32'h0,         32'h0000_0107, 4'd9},  // R9
        {2'd0, 12'h180, 4'hF, 32'h0000_0080, 32'h0, 4'd5},  // R5
        {2'd2, 12'h000, 4'hF, 32'h0,         32'h0000_0105, 4'd9},  // R9
        {2'd0, 12'h180, 4'hF, 32'h0000_0020, 32'h0, 4'd5},  // R5
        {2'd2, 12'h000, 4'hF, 32'h0,         32'h0000_0000, 4'd9},  // R9
        {2'd1, 12'h180, 4'hF, 32'h0,         32'h0000_0000, 4'd5},  // R5
        {2'd0, 12'h304, 4'hF, 32'h0000_0000, 32'h0, 4'd7},  // R7
        {2'd0, 12'h100, 4'hF, 32'h0000_0060, 32'h0, 4'd5},  // R5
        {2'd2, 12'h000, 4'hF, 32'h0,         32'h0000_0105, 4'd9},  // R9 tie
        {2'd0, 12'h044, 4'hF, 32'hFFFF_FFFF, 32'h0, 4'd11}, // R11
        {2'd1, 12'h044, 4'hF, 32'h0,         32'h0000_0000, 4'd11}, // R11
        {2'd1, 12'h000, 4'hF, 32'h0,         32'h0000_00E0, 4'd11}, // R11
        {2'd0, 12'h002, 4'hF, 32'hFFFF_FFFF, 32'h0, 4'd11}  // R11
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] irq_req = '0;
    logic        irq_ack = 1'b0;
    logic        irq_valid;
    logic [4:0]  irq_id;
    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_ctrl_bank i_irq_ctrl_bank (
        .clk(clk), .rst(rst), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_ack(irq_ack),
        .irq_valid(irq_valid), .irq_id(irq_id)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input string rq, input logic [11:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(rq, reg_rdata, exp);
    endtask

    function automatic logic [31:0] arb();
        return {23'b0, irq_valid, 3'b0, irq_id};
    endfunction

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD*50000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        #1;
        chk("R1 valid", arb(), 32'h0);
        rd("R1 enable", 12'h000, 32'h0);
        rd("R1 pending", 12'h100, 32'h0);
        rd("R1 priority", 12'h31C, 32'h0);

        for (int i = 0; i < NT; i++) begin
            logic [85:0] e;
            e = TBL[i];
            if (e[85:84] == 2'd0) begin
                wr(e[83:72], e[71:68], e[67:36]);
            end else if (e[85:84] == 2'd1) begin
                rd($sformatf("table[%0d] R%0d", i, e[3:0]), e[83:72], e[35:4]);
            end else begin
                #1;
                chk($sformatf("table[%0d] R%0d", i, e[3:0]), arb(), e[35:4]);
            end
        end
        rd("R11 misaligned write ignored", 12'h000, 32'h0000_00E0);

        // R8 partial strobes
        wr(12'h300, 4'h7, 32'hFFFF_FFFF);
        rd("R8 partial prio write ignored", 12'h300, 32'h0);
        wr(12'h000, 4'h1, 32'hFFFF_FFFF);
        rd("R8 strobed lane only", 12'h000, 32'h0000_00FF);

        // Clean slate
        wr(12'h180, 4'hF, 32'hFFFF_FFFF);
        wr(12'h080, 4'hF, 32'hFFFF_FFFF);
        rd("R3 all disabled", 12'h000, 32'h0);

        // R6 pulse on a disabled line
        @(negedge clk); irq_req[10] = 1'b1;
        @(negedge clk); irq_req[10] = 1'b0;
        rd("R6 pulse sets pending", 12'h100, 32'h0000_0400);
        #1; chk("R9 disabled line not chosen", arb(), 32'h0);

        // R10 acknowledge
        wr(12'h000, 4'hF, 32'h0000_1400);
        wr(12'h100, 4'hF, 32'h0000_1000);
        #1; chk("R9 equal prio lowest id", arb(), 32'h0000_010A);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        #1; chk("R10 next winner after ack", arb(), 32'h0000_010C);
        rd("R10 pending after ack", 12'h100, 32'h0000_1000);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        #1; chk("R10 none left", arb(), 32'h0);
        wr(12'h100, 4'hF, 32'h0000_0008);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        rd("R10 ack without valid ignored", 12'h100, 32'h0000_0008);

        // R6 set beats clear
        @(negedge clk);
        irq_req[3] = 1'b1;
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = 12'h180; reg_be = 4'hF;
        reg_wdata = 32'h0000_0008;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0; irq_req[3] = 1'b0;
        rd("R6 request beats clear", 12'h100, 32'h0000_0008);
        wr(12'h180, 4'hF, 32'h0000_0008);
        rd("R5 cleared", 12'h100, 32'h0);

        // R7 / R9 top line
        wr(12'h31C, 4'hF, 32'hFFFF_FFFF);
        rd("R7 line 31 word", 12'h31C, 32'hC0C0_C0C0);
        wr(12'h31C, 4'hF, 32'hC000_0000);
        rd("R7 line 31 lane", 12'h31C, 32'hC000_0000);
        wr(12'h300, 4'hF, 32'h0000_00FF);
        wr(12'h000, 4'hF, 32'h8000_0001);
        wr(12'h100, 4'hF, 32'h8000_0001);
        #1; chk("R9 tie at prio 3 to line 0", arb(), 32'h0000_0100);
        wr(12'h31C, 4'hF, 32'h8000_0000);
        #1; chk("R9 line 31 wins", arb(), 32'h0000_011F);

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1; chk("R1 valid after reset", arb(), 32'h0);
        rd("R1 enable after reset", 12'h080, 32'h0);
        rd("R1 pending after reset", 12'h180, 32'h0);
        rd("R1 priority after reset", 12'h31C, 32'h0);
        finish_run();
    end

endmodule